// File: doc/BRIEF.md
# Ethernet PHY Loopback Path Controller

This block sits between the MAC-facing transmit data and the receive data that goes back to the MAC inside a 10 Mb/s Ethernet transceiver. On every clock it decides whether transmitted data is returned on the receive output (internal loopback) or whether the line receiver drives that output. It also reports whether loopback is active and whether collision detection may run. The line coding datapath, the analog interfaces and the jabber timer are outside the block. It only chooses and qualifies the path, using the status those other parts supply.

The decision is a fixed priority. The external-test control, which is active low, comes first. Port type comes next: twisted pair or the attachment-unit interface (AUI). On the twisted-pair port, link-fail and jabber status follow. Then come the force control and the collision status. The decision is captured in a state register named after the selected path. The receive data and valid flag are registered as well, so every output changes only at a clock edge, one cycle after the inputs that caused it.

Top module: `lbk_loopback_ctrl`

States of the path register:
- `PATH_LINE`: the line receiver drives the receive output.
- `PATH_TP_NORMAL`: normal twisted-pair loopback.
- `PATH_TP_FORCED`: forced twisted-pair loopback, which holds through a collision.
- `PATH_AUI_LOOP`: AUI loopback.
- `PATH_EXT_TEST`: external test mode, with internal loopback and collision detection both off.

Transitions:
- Every state goes to `PATH_EXT_TEST` when `ext_lb_n` is low.
- Otherwise, on the AUI port, the next state is `PATH_AUI_LOOP` when `force_lb` and `tx_en` are both high, and `PATH_LINE` in every other case.
- Otherwise, on the twisted-pair port, the next state is `PATH_LINE` when `link_fail` or `jabber` is high.
- Failing that, the next state is `PATH_TP_FORCED` when `tx_en` and `force_lb` are high.
- Failing that, the next state is `PATH_TP_NORMAL` when `tx_en` is high and `collision` is low.
- In all remaining cases the next state is `PATH_LINE`.

The next state depends only on the present inputs and never on the current state.

## Requirements
- R1: While `rst_n` is low, `rx_data` is 0, `rx_valid` is 0, `lb_active` is 0 and `col_det_en` is 1.
- R2: With the twisted-pair port selected (`port_aui`=0), `ext_lb_n`=1, `tx_en`=1 and `collision`, `link_fail` and `jabber` all 0, the next cycle shows `lb_active`=1, `rx_valid`=1 and `rx_data` equal to `tx_data`.
- R3: On the twisted-pair port with `force_lb`=0, a high `collision` drops normal loopback. The next cycle then carries the line receive data and valid flag, with `lb_active`=0.
- R4: On the twisted-pair port, a high `link_fail` or `jabber` disables loopback, even when `force_lb`=1.
- R5: On the twisted-pair port with `force_lb`=1, `tx_en`=1, `ext_lb_n`=1 and no link-fail or jabber, loopback is active in the next cycle even while `collision` is high.
- R6: With the AUI port selected (`port_aui`=1), loopback happens only when `force_lb`=1 and `tx_en`=1. Collision, link-fail and jabber have no effect on it. With `force_lb`=0 there is no AUI loopback.
- R7: When `ext_lb_n` is 0, on either port and whatever `force_lb` is, the next cycle shows `lb_active`=0, `col_det_en`=0 and receive data taken from the line.
- R8: When `ext_lb_n` is 1, the next cycle shows `col_det_en`=1.
- R9: Whenever loopback is not active, including when `tx_en`=0, `rx_data` and `rx_valid` equal the previous cycle's `line_rx_data` and `line_rx_valid`.
- R10: All outputs are registered and follow their inputs with exactly one clock of latency. While loopback is active, `rx_data` equals the previous cycle's `tx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_aui | input | 1 | Port select: 1 = AUI, 0 = twisted pair |
| force_lb | input | 1 | Force-loopback control |
| ext_lb_n | input | 1 | External test mode, active low |
| collision | input | 1 | Collision status |
| link_fail | input | 1 | Link-fail status |
| jabber | input | 1 | Jabber status |
| tx_en | input | 1 | Transmit enable from the MAC side |
| tx_data | input | DW | Transmit data from the MAC side |
| line_rx_data | input | DW | Receive data from the line decoder |
| line_rx_valid | input | 1 | Valid flag for line receive data |
| rx_data | output | DW | Receive data to the MAC side |
| rx_valid | output | 1 | Receive valid to the MAC side |
| col_det_en | output | 1 | Collision-detect enable |
| lb_active | output | 1 | Internal loopback is active |

## Verification
The assertions assume that every control and status input is synchronous to `clk` and settles between edges. They also assume that the status inputs carry no meaning before the first edge after reset, which is why each check arms only from the second edge. The stimulus meets both assumptions. It changes every input only on the falling edge and does not drive any vector until reset has been released. It then walks through the priority order: AUI and twisted pair, force high and low, collision, link-fail and jabber singly and together, and the external test mode on both ports. The line data and the transmit data differ in every vector, so the bench can always tell which source drove the receive output.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    // Path states; encoding is free, decode is done by case.
    typedef enum logic [2:0] {
        PATH_LINE      = 3'd0,
        PATH_TP_NORMAL = 3'd1,
        PATH_TP_FORCED = 3'd2,
        PATH_AUI_LOOP  = 3'd3,
        PATH_EXT_TEST  = 3'd4
    } path_e;

    // True for every state in which transmit data returns on receive.
    function automatic logic path_loops(input path_e p);
        logic r;
        unique case (p)
            PATH_TP_NORMAL,
            PATH_TP_FORCED,
            PATH_AUI_LOOP:  r = 1'b1;
            default:        r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lbk_path_arbiter.sv
module lbk_path_arbiter
    import lbk_pkg::*;
(
    input  logic  port_aui,
    input  logic  force_lb,
    input  logic  ext_lb_n,
    input  logic  collision,
    input  logic  link_fail,
    input  logic  jabber,
    input  logic  tx_en,
    output path_e path_nxt
);

    // Fixed priority: external test, then port type, then status, then force.
    always_comb begin
        path_nxt = PATH_LINE;
        if (!ext_lb_n) begin
            path_nxt = PATH_EXT_TEST;
        end else if (port_aui) begin
            if (force_lb && tx_en)
                path_nxt = PATH_AUI_LOOP;
        end else if (link_fail || jabber) begin
            path_nxt = PATH_LINE;
        end else if (tx_en && force_lb) begin
            path_nxt = PATH_TP_FORCED;
        end else if (tx_en && !collision) begin
            path_nxt = PATH_TP_NORMAL;
        end
    end

endmodule

// File: rtl/lbk_rx_select.sv
module lbk_rx_select
    import lbk_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  path_e         path_nxt,
    input  logic          tx_en,
    input  logic [DW-1:0] tx_data,
    input  logic [DW-1:0] line_rx_data,
    input  logic          line_rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          lb_active,
    output logic          col_det_en
);

    localparam logic [DW-1:0] DATA_ZERO = '0;

    path_e path_q;
    logic  lb_q;
    logic  cd_q;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) path_q <= PATH_LINE;
        else        path_q <= path_nxt;
    end

    // Receive data register, steered by the path being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data  <= DATA_ZERO;
            rx_valid <= 1'b0;
        end else if (path_loops(path_nxt)) begin
            rx_data  <= tx_data;
            rx_valid <= tx_en;
        end else begin
            rx_data  <= line_rx_data;
            rx_valid <= line_rx_valid;
        end
    end

    // Status outputs decoded from the state register only.
    always_comb begin
        unique case (path_q)
            PATH_LINE:      begin lb_q = 1'b0; cd_q = 1'b1; end
            PATH_TP_NORMAL: begin lb_q = 1'b1; cd_q = 1'b1; end
            PATH_TP_FORCED: begin lb_q = 1'b1; cd_q = 1'b1; end
            PATH_AUI_LOOP:  begin lb_q = 1'b1; cd_q = 1'b1; end
            PATH_EXT_TEST:  begin lb_q = 1'b0; cd_q = 1'b0; end
            default:        begin lb_q = 1'b0; cd_q = 1'b1; end
        endcase
    end

    assign lb_active  = lb_q;
    assign col_det_en = cd_q;

endmodule

// File: rtl/lbk_loopback_ctrl.sv
module lbk_loopback_ctrl
    import lbk_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_aui,
    input  logic          force_lb,
    input  logic          ext_lb_n,
    input  logic          collision,
    input  logic          link_fail,
    input  logic          jabber,
    input  logic          tx_en,
    input  logic [DW-1:0] tx_data,
    input  logic [DW-1:0] line_rx_data,
    input  logic          line_rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          col_det_en,
    output logic          lb_active
);

    path_e path_nxt;

    lbk_path_arbiter u_arb (
        .port_aui  (port_aui),
        .force_lb  (force_lb),
        .ext_lb_n  (ext_lb_n),
        .collision (collision),
        .link_fail (link_fail),
        .jabber    (jabber),
        .tx_en     (tx_en),
        .path_nxt  (path_nxt)
    );

    lbk_rx_select #(.DW(DW)) u_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .path_nxt      (path_nxt),
        .tx_en         (tx_en),
        .tx_data       (tx_data),
        .line_rx_data  (line_rx_data),
        .line_rx_valid (line_rx_valid),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .lb_active     (lb_active),
        .col_det_en    (col_det_en)
    );

endmodule

// File: rtl/lbk_loop_checker.sv
module lbk_loop_checker #(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          port_aui,
    input logic          force_lb,
    input logic          ext_lb_n,
    input logic          collision,
    input logic          link_fail,
    input logic          jabber,
    input logic          tx_en,
    input logic [DW-1:0] tx_data,
    input logic [DW-1:0] line_rx_data,
    input logic          line_rx_valid,
    input logic [DW-1:0] rx_data,
    input logic          rx_valid,
    input logic          col_det_en,
    input logic          lb_active
);

    // Arms one edge after reset release so $past never sees reset-time inputs.
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        if (!rst_n) begin
            assert_reset_state_R1: assert (rx_valid == 1'b0 && lb_active == 1'b0 && col_det_en == 1'b1);
        end
    end

    assert_tp_normal_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ext_lb_n && !port_aui && tx_en && !collision && !link_fail && !jabber) |-> lb_active);

    assert_collision_drop_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ext_lb_n && !port_aui && !force_lb && collision) |-> !lb_active);

    assert_linkfail_jabber_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!port_aui && (link_fail || jabber)) |-> !lb_active);

    assert_forced_tp_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ext_lb_n && !port_aui && force_lb && tx_en && !link_fail && !jabber) |-> lb_active);

    assert_aui_force_only_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(port_aui && ext_lb_n) |-> (lb_active == $past(force_lb && tx_en)));

    assert_ext_test_R7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(!ext_lb_n) |-> (!lb_active && !col_det_en));

    assert_coldet_on_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(ext_lb_n) |-> col_det_en);

    assert_line_source_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !lb_active |-> (rx_data == $past(line_rx_data) && rx_valid == $past(line_rx_valid)));

    assert_loop_source_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        lb_active |-> (rx_data == $past(tx_data) && rx_valid && $past(tx_en)));

endmodule

bind lbk_loopback_ctrl lbk_loop_checker #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_aui      (port_aui),
    .force_lb      (force_lb),
    .ext_lb_n      (ext_lb_n),
    .collision     (collision),
    .link_fail     (link_fail),
    .jabber        (jabber),
    .tx_en         (tx_en),
    .tx_data       (tx_data),
    .line_rx_data  (line_rx_data),
    .line_rx_valid (line_rx_valid),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .col_det_en    (col_det_en),
    .lb_active     (lb_active)
);

// File: tb/tb_lbk_loopback_ctrl.sv
`timescale 1ns/1ps
module tb_lbk_loopback_ctrl;

    localparam int  DW      = 4;
    localparam time CLK_PER = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          port_aui, force_lb, ext_lb_n, collision, link_fail, jabber, tx_en;
    logic [DW-1:0] tx_data, line_rx_data;
    logic          line_rx_valid;
    logic [DW-1:0] rx_data;
    logic          rx_valid, col_det_en, lb_active;

    typedef struct {
        logic [DW-1:0] d;
        logic          v;
        logic          lb;
        logic          cd;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    always #(CLK_PER/2) clk = ~clk;

    lbk_loopback_ctrl #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .port_aui(port_aui), .force_lb(force_lb),
        .ext_lb_n(ext_lb_n), .collision(collision), .link_fail(link_fail),
        .jabber(jabber), .tx_en(tx_en), .tx_data(tx_data),
        .line_rx_data(line_rx_data), .line_rx_valid(line_rx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .col_det_en(col_det_en),
        .lb_active(lb_active)
    );

    // Reference decision written from the requirements.
    function automatic logic want_loop(logic aui, logic frc, logic extn, logic col,
                                       logic lf, logic jab, logic ten);
        if (!extn) return 1'b0;                 // R7
        if (aui)   return frc && ten;           // R6
        if (lf || jab) return 1'b0;             // R4
        if (frc && ten) return 1'b1;            // R5
        return ten && !col;                     // R2, R3
    endfunction

    // Driver: drive on the falling edge and push the expected result.
    task automatic drive(input logic aui, input logic frc, input logic extn,
                         input logic col, input logic lf, input logic jab,
                         input logic ten, input logic [DW-1:0] td,
                         input logic [DW-1:0] ld, input logic lv, input string tag);
        exp_t e;
        logic lp;
        @(negedge clk);
        port_aui = aui; force_lb = frc; ext_lb_n = extn; collision = col;
        link_fail = lf; jabber = jab; tx_en = ten; tx_data = td;
        line_rx_data = ld; line_rx_valid = lv;
        lp   = want_loop(aui, frc, extn, col, lf, jab, ten);
        e.d  = lp ? td  : ld;
        e.v  = lp ? ten : lv;
        e.lb = lp;
        e.cd = extn;                            // R8
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compare just after the edge that captured the pushed item (R10).
    always @(posedge clk) begin
        #1;
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (rx_data !== e.d || rx_valid !== e.v || lb_active !== e.lb || col_det_en !== e.cd) begin
                n_fail++;
                $display("FAIL %s: got d=%h v=%b lb=%b cd=%b, expected d=%h v=%b lb=%b cd=%b",
                         e.tag, rx_data, rx_valid, lb_active, col_det_en, e.d, e.v, e.lb, e.cd);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        port_aui = 0; force_lb = 0; ext_lb_n = 1; collision = 0; link_fail = 0;
        jabber = 0; tx_en = 0; tx_data = '0; line_rx_data = '0; line_rx_valid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;  // R1 reset state
        if (rx_data !== '0 || rx_valid !== 1'b0 || lb_active !== 1'b0 || col_det_en !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: got d=%h v=%b lb=%b cd=%b, expected d=0 v=0 lb=0 cd=1",
                     rx_data, rx_valid, lb_active, col_det_en);
        end
        rst_n = 1'b1;

        //     aui frc ext col lf jab ten  td    ld    lv
        drive(0, 0, 1, 0, 0, 0, 1, 4'hA, 4'h5, 1, "R2 tp normal loop");
        drive(0, 0, 1, 0, 0, 0, 1, 4'h3, 4'hC, 0, "R10 tp loop follows tx");
        drive(0, 0, 1, 0, 0, 0, 0, 4'h7, 4'h9, 1, "R9 tx idle line path");
        drive(0, 0, 1, 1, 0, 0, 1, 4'hB, 4'h2, 1, "R3 collision drops loop");
        drive(0, 1, 1, 1, 0, 0, 1, 4'hE, 4'h1, 0, "R5 force holds through collision");
        drive(0, 1, 1, 0, 0, 0, 1, 4'h6, 4'h8, 1, "R5 force no collision");
        drive(0, 0, 1, 0, 1, 0, 1, 4'hF, 4'h4, 1, "R4 link fail");
        drive(0, 1, 1, 1, 0, 1, 1, 4'hD, 4'h0, 1, "R4 jabber with force");
        drive(0, 1, 1, 0, 1, 1, 1, 4'h2, 4'hA, 0, "R4 link fail and jabber");
        drive(1, 1, 1, 0, 0, 0, 1, 4'hC, 4'h3, 0, "R6 aui forced loop");
        drive(1, 0, 1, 0, 0, 0, 1, 4'h9, 4'h6, 1, "R6 aui no force");
        drive(1, 1, 1, 1, 1, 1, 1, 4'h5, 4'hB, 0, "R6 aui ignores status");
        drive(1, 1, 1, 0, 0, 0, 0, 4'h1, 4'h7, 1, "R6 aui force tx idle");
        drive(0, 1, 0, 0, 0, 0, 1, 4'h8, 4'hE, 1, "R7 ext test on tp");
        drive(1, 1, 0, 1, 0, 0, 1, 4'h4, 4'hD, 0, "R7 ext test on aui");
        drive(0, 0, 1, 0, 0, 0, 1, 4'h0, 4'hF, 1, "R8 coldet back on");
        drive(0, 0, 0, 0, 0, 0, 0, 4'h6, 4'h2, 1, "R7 ext test idle");
        drive(0, 0, 1, 1, 0, 0, 0, 4'h3, 4'h5, 1, "R9 collision idle line");
        drive(0, 0, 1, 0, 0, 0, 1, 4'hA, 4'h1, 1, "R2 loop after line");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule